// File: doc/BRIEF.md
# Fixed Eight-Step Instruction Sequencer

This block is the control unit of a small 8-bit accumulator machine. It holds the program counter and the instruction register. An opcode decoder and a step state machine drive every datapath control line. Each instruction runs for exactly eight clock steps. Steps 0 to 2 are a fetch shared by all instructions, and steps 3 to 7 carry out the instruction. The memory, the memory address register, the accumulator and the ALU sit outside the block. The block tells them when to load, read, write and which ALU function to apply. It reads back only the 8-bit data bus and the negative and zero flags.

The step machine has nine named states. `ST_FETCH_ADDR` (step 0) loads the MAR from the PC. `ST_FETCH_READ` (step 1) reads memory and increments the PC. `ST_FETCH_LATCH` (step 2) latches the opcode into the instruction register. `ST_EXEC_3` to `ST_EXEC_7` (steps 3 to 7) execute the instruction. `ST_HALTED` is the state after a halt. The transitions run in order, each state leading to the next in one cycle, and `ST_EXEC_7` returns to `ST_FETCH_ADDR`. There is one exception: `ST_EXEC_3` goes to `ST_HALTED` when the decoded instruction is a halt. `ST_HALTED` has no exit except reset.

The decoder turns the upper opcode nibble into eleven one-hot instruction lines. A flag-controlled mux then rewrites the conditional jumps. A taken conditional jump runs the unconditional-jump sequence. A conditional jump that is not taken runs a skip sequence, which steps the PC over the address byte.

Top module: `seq8_ctrl`

## Requirements
- R1: Every instruction other than a halt takes exactly eight cycles. `step_q` counts 0,1,...,7 and then wraps to 0.
- R2: At step 0, `mar_load` is 1 and `mar_src` selects the PC (bit 0). At step 1, `mem_rd` is 1 and the PC increments. At step 2, `mem_rd` and `ir_load` are 1, and the instruction register takes `bus_in`.
- R3: Only `ir_q[7:4]` selects the instruction, and exactly one of the eleven internal lines is active. The encodings are 0x0 no-op, 0x1 store, 0x2 load, 0x3 add, 0x4 or, 0x5 and, 0x6 invert, 0x8 jump, 0x9 jump-if-negative, 0xA jump-if-zero and 0xF halt. Every other code acts as a no-op that leaves the PC one past the opcode.
- R4: A memory-operand instruction (store, load, add, or, and) runs this sequence. Step 3 loads the MAR from the PC. Step 4 reads the operand byte and increments the PC. Step 5 reads and loads the MAR from the bus (bit 1 of `mar_src`). A store asserts `mem_wr` at step 6. The other four read at step 6 and assert `acc_load` at step 7. `mem_rd` and `mem_wr` are never 1 together.
- R5: A jump, or a conditional jump whose flag is 1, loads the PC from `bus_in` at step 5. That is the operand byte that follows the opcode.
- R6: Jump-if-negative tests `flag_n` and jump-if-zero tests `flag_z`. If the tested flag is 0, the PC increments once at step 3, and the PC ends two past the opcode.
- R7: The PC changes only through `pc_sel`. Bit 0 increments and bit 1 loads from the bus, and at most one bit is set. When `pc_sel` is 0 the PC holds.
- R8: A halt enters `ST_HALTED` after step 3. `halted` then stays 1, and `step_q` and the PC stay frozen until reset.
- R9: Reset (active-low `rst_n`) clears the PC, the instruction register and the step to 0 and clears `halted`.
- R10: `alu_sel` is one-hot and is non-zero only while `acc_load` is 1. Bit 0 passes the bus, bit 1 adds, bit 2 ORs, bit 3 ANDs and bit 4 inverts the accumulator. The invert instruction loads the accumulator at step 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 8 | Data bus (memory read data) |
| flag_n | input | 1 | Accumulator negative flag |
| flag_z | input | 1 | Accumulator zero flag |
| pc_q | output | 8 | Program counter |
| ir_q | output | 8 | Instruction register |
| step_q | output | 3 | Current step 0..7 |
| halted | output | 1 | Halt state reached |
| mar_load | output | 1 | Load the memory address register |
| mar_src | output | 2 | One-hot MAR source: bit0 PC, bit1 bus |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write of the accumulator |
| mdr_load | output | 1 | Load the memory data register |
| ir_load | output | 1 | Instruction register load strobe |
| acc_load | output | 1 | Load the accumulator with the ALU result |
| alu_sel | output | 5 | One-hot ALU function |
| pc_sel | output | 2 | One-hot PC update: bit0 increment, bit1 load |

## Verification
The hardest case to reach from the ports is a conditional jump in each of its states. Each of the two flags must be both set and clear at the moment a jump-if-negative or jump-if-zero reaches step 3. The flags come from an accumulator that only the block's own controls can change. The bench therefore models the memory, the MAR and the accumulator. It runs a program whose add makes the accumulator zero and whose invert makes it negative. This places a taken and a not-taken case of each conditional jump, and an undefined opcode, in one run. A reference model of the instruction set predicts the PC and the accumulator at every instruction boundary.

// File: rtl/seq8_pkg.sv
package seq8_pkg;

    localparam int WORD_W    = 8;
    localparam int STEP_W    = 3;
    localparam int NUM_LINES = 11;
    localparam int ALU_W     = 5;

    // instruction line indices
    localparam int LN_NOP = 0;
    localparam int LN_STA = 1;
    localparam int LN_LDA = 2;
    localparam int LN_ADD = 3;
    localparam int LN_OR  = 4;
    localparam int LN_AND = 5;
    localparam int LN_NOT = 6;
    localparam int LN_JMP = 7;
    localparam int LN_JN  = 8;
    localparam int LN_JZ  = 9;
    localparam int LN_HLT = 10;

    // ALU select bits
    localparam int ALU_PASS = 0;
    localparam int ALU_ADD  = 1;
    localparam int ALU_OR   = 2;
    localparam int ALU_AND  = 3;
    localparam int ALU_NOT  = 4;

    // PC update bits and MAR source bits
    localparam int PCS_INC  = 0;
    localparam int PCS_LOAD = 1;
    localparam int MS_PC    = 0;
    localparam int MS_BUS   = 1;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_STA = 4'h1,
        OP_LDA = 4'h2,
        OP_ADD = 4'h3,
        OP_OR  = 4'h4,
        OP_AND = 4'h5,
        OP_NOT = 4'h6,
        OP_JMP = 4'h8,
        OP_JN  = 4'h9,
        OP_JZ  = 4'hA,
        OP_HLT = 4'hF
    } opcode_e;

    typedef enum logic [3:0] {
        ST_FETCH_ADDR  = 4'd0,
        ST_FETCH_READ  = 4'd1,
        ST_FETCH_LATCH = 4'd2,
        ST_EXEC_3      = 4'd3,
        ST_EXEC_4      = 4'd4,
        ST_EXEC_5      = 4'd5,
        ST_EXEC_6      = 4'd6,
        ST_EXEC_7      = 4'd7,
        ST_HALTED      = 4'd8
    } step_state_e;

endpackage

// File: rtl/seq8_steps.sv
module seq8_steps
    import seq8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    output step_state_e       state,
    output logic [STEP_W-1:0] step_q,
    output logic              halted
);

    step_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH_ADDR;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH_ADDR:  state_nx = ST_FETCH_READ;
            ST_FETCH_READ:  state_nx = ST_FETCH_LATCH;
            ST_FETCH_LATCH: state_nx = ST_EXEC_3;
            ST_EXEC_3:      state_nx = halt_req ? ST_HALTED : ST_EXEC_4;
            ST_EXEC_4:      state_nx = ST_EXEC_5;
            ST_EXEC_5:      state_nx = ST_EXEC_6;
            ST_EXEC_6:      state_nx = ST_EXEC_7;
            ST_EXEC_7:      state_nx = ST_FETCH_ADDR;
            ST_HALTED:      state_nx = ST_HALTED;
            default:        state_nx = ST_FETCH_ADDR;
        endcase
    end

    always_comb begin
        halted = 1'b0;
        step_q = '0;
        unique case (state)
            ST_HALTED: begin
                halted = 1'b1;
                step_q = STEP_W'(3);
            end
            default: step_q = state[STEP_W-1:0];
        endcase
    end

    a_r1_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !halt_req) |=> (step_q == STEP_W'($past(step_q) + 1'b1)));

    a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(step_q)));

endmodule

// File: rtl/seq8_decoder.sv
module seq8_decoder
    import seq8_pkg::*;
(
    input  logic [3:0]           op_nib,
    output logic [NUM_LINES-1:0] lines
);

    always_comb begin
        lines = '0;
        case (op_nib)
            OP_STA:  lines[LN_STA] = 1'b1;
            OP_LDA:  lines[LN_LDA] = 1'b1;
            OP_ADD:  lines[LN_ADD] = 1'b1;
            OP_OR:   lines[LN_OR]  = 1'b1;
            OP_AND:  lines[LN_AND] = 1'b1;
            OP_NOT:  lines[LN_NOT] = 1'b1;
            OP_JMP:  lines[LN_JMP] = 1'b1;
            OP_JN:   lines[LN_JN]  = 1'b1;
            OP_JZ:   lines[LN_JZ]  = 1'b1;
            OP_HLT:  lines[LN_HLT] = 1'b1;
            default: lines[LN_NOP] = 1'b1;
        endcase
    end

endmodule

// File: rtl/seq8_jump_mux.sv
module seq8_jump_mux
    import seq8_pkg::*;
(
    input  logic [NUM_LINES-1:0] lines_in,
    input  logic                 flag_n,
    input  logic                 flag_z,
    output logic [NUM_LINES-1:0] lines_out
);

    logic take;
    assign take = (lines_in[LN_JN] & flag_n) | (lines_in[LN_JZ] & flag_z);

    // A taken conditional becomes the jump line; a refused one keeps its own
    // line, which the control stage reads as "skip the address byte".
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        if (g == LN_JMP) begin : g_jmp
            assign lines_out[g] = lines_in[g] | take;
        end else if (g == LN_JN || g == LN_JZ) begin : g_cond
            assign lines_out[g] = lines_in[g] & ~take;
        end else begin : g_pass
            assign lines_out[g] = lines_in[g];
        end
    end

endmodule

// File: rtl/seq8_ctrl_out.sv
module seq8_ctrl_out
    import seq8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  step_state_e          state,
    input  logic [NUM_LINES-1:0] lines,
    output logic                 mar_load,
    output logic [1:0]           mar_src,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 mdr_load,
    output logic                 ir_load,
    output logic                 acc_load,
    output logic [ALU_W-1:0]     alu_sel,
    output logic [1:0]           pc_sel
);

    logic is_store, is_read_op, is_mem_op, is_go, is_skip;

    assign is_store   = lines[LN_STA];
    assign is_read_op = lines[LN_LDA] | lines[LN_ADD] | lines[LN_OR] | lines[LN_AND];
    assign is_mem_op  = is_store | is_read_op;
    assign is_go      = lines[LN_JMP];
    assign is_skip    = lines[LN_JN] | lines[LN_JZ];

    always_comb begin
        mar_load = 1'b0;
        mar_src  = '0;
        mem_rd   = 1'b0;
        mem_wr   = 1'b0;
        mdr_load = 1'b0;
        ir_load  = 1'b0;
        acc_load = 1'b0;
        alu_sel  = '0;
        pc_sel   = '0;
        unique case (state)
            ST_FETCH_ADDR: begin
                mar_load       = 1'b1;
                mar_src[MS_PC] = 1'b1;
            end
            ST_FETCH_READ: begin
                mem_rd          = 1'b1;
                mdr_load        = 1'b1;
                pc_sel[PCS_INC] = 1'b1;
            end
            ST_FETCH_LATCH: begin
                mem_rd  = 1'b1;
                ir_load = 1'b1;
            end
            ST_EXEC_3: begin
                if (is_mem_op || is_go) begin
                    mar_load       = 1'b1;
                    mar_src[MS_PC] = 1'b1;
                end else if (is_skip) begin
                    pc_sel[PCS_INC] = 1'b1;
                end else if (lines[LN_NOT]) begin
                    acc_load         = 1'b1;
                    alu_sel[ALU_NOT] = 1'b1;
                end
            end
            ST_EXEC_4: begin
                if (is_mem_op || is_go) begin
                    mem_rd   = 1'b1;
                    mdr_load = 1'b1;
                end
                if (is_mem_op) pc_sel[PCS_INC] = 1'b1;
            end
            ST_EXEC_5: begin
                if (is_mem_op) begin
                    mem_rd          = 1'b1;
                    mar_load        = 1'b1;
                    mar_src[MS_BUS] = 1'b1;
                end else if (is_go) begin
                    mem_rd           = 1'b1;
                    pc_sel[PCS_LOAD] = 1'b1;
                end
            end
            ST_EXEC_6: begin
                if (is_store) begin
                    mem_wr = 1'b1;
                end else if (is_read_op) begin
                    mem_rd   = 1'b1;
                    mdr_load = 1'b1;
                end
            end
            ST_EXEC_7: begin
                if (is_read_op) begin
                    mem_rd   = 1'b1;
                    acc_load = 1'b1;
                    alu_sel[ALU_PASS] = lines[LN_LDA];
                    alu_sel[ALU_ADD]  = lines[LN_ADD];
                    alu_sel[ALU_OR]   = lines[LN_OR];
                    alu_sel[ALU_AND]  = lines[LN_AND];
                end
            end
            ST_HALTED: ;
            default: ;
        endcase
    end

    a_r3_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FETCH_ADDR) |-> $onehot(lines));

    a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r10_alu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alu_sel) && ((alu_sel != '0) -> acc_load) && (acc_load -> $onehot(alu_sel)));

endmodule

// File: rtl/seq8_ctrl.sv
module seq8_ctrl
    import seq8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    bus_in,
    input  logic                 flag_n,
    input  logic                 flag_z,
    output logic [WORD_W-1:0]    pc_q,
    output logic [WORD_W-1:0]    ir_q,
    output logic [STEP_W-1:0]    step_q,
    output logic                 halted,
    output logic                 mar_load,
    output logic [1:0]           mar_src,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic                 mdr_load,
    output logic                 ir_load,
    output logic                 acc_load,
    output logic [ALU_W-1:0]     alu_sel,
    output logic [1:0]           pc_sel
);

    step_state_e          state;
    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] eff_lines;
    logic                 halt_req;

    assign halt_req = (state == ST_EXEC_3) && raw_lines[LN_HLT];

    seq8_steps u_steps (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .state    (state),
        .step_q   (step_q),
        .halted   (halted)
    );

    seq8_decoder u_dec (
        .op_nib (ir_q[WORD_W-1 -: 4]),
        .lines  (raw_lines)
    );

    seq8_jump_mux u_jmux (
        .lines_in  (raw_lines),
        .flag_n    (flag_n),
        .flag_z    (flag_z),
        .lines_out (eff_lines)
    );

    seq8_ctrl_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .lines    (eff_lines),
        .mar_load (mar_load),
        .mar_src  (mar_src),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .mdr_load (mdr_load),
        .ir_load  (ir_load),
        .acc_load (acc_load),
        .alu_sel  (alu_sel),
        .pc_sel   (pc_sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pc_sel[PCS_INC]) begin
            pc_q <= pc_q + 1'b1;
        end else if (pc_sel[PCS_LOAD]) begin
            pc_q <= bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ir_q <= '0;
        else if (ir_load) ir_q <= bus_in;
    end

    a_r7_pc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pc_sel));

    a_r7_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == '0) |=> $stable(pc_q));

    a_r5_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel[PCS_LOAD] |=> (pc_q == $past(bus_in)));

    a_r2_fetch_mar: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == '0 && !halted) |-> (mar_load && mar_src[MS_PC]));

    a_r8_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_q));

endmodule

// File: tb/seq8_ctrl_tb.sv
`timescale 1ns/1ps
module seq8_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in;
    logic       flag_n, flag_z;
    logic [7:0] pc_q, ir_q;
    logic [2:0] step_q;
    logic       halted, mar_load, mem_rd, mem_wr, mdr_load, ir_load, acc_load;
    logic [1:0] mar_src, pc_sel;
    logic [4:0] alu_sel;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    seq8_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .flag_n(flag_n), .flag_z(flag_z),
        .pc_q(pc_q), .ir_q(ir_q), .step_q(step_q), .halted(halted),
        .mar_load(mar_load), .mar_src(mar_src), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mdr_load(mdr_load), .ir_load(ir_load), .acc_load(acc_load),
        .alu_sel(alu_sel), .pc_sel(pc_sel)
    );

    // program image, computed per address
    function automatic logic [7:0] prog_byte(int a);
        case (a)
            8'h00: return 8'h20; 8'h01: return 8'h80;   // load [80]
            8'h02: return 8'h30; 8'h03: return 8'h81;   // add [81] -> zero
            8'h04: return 8'hA0; 8'h05: return 8'h0A;   // jz taken
            8'h06: return 8'hF0;                        // skipped halt
            8'h0A: return 8'h60;                        // invert -> FF
            8'h0B: return 8'hA0; 8'h0C: return 8'h06;   // jz not taken
            8'h0D: return 8'h90; 8'h0E: return 8'h10;   // jn taken
            8'h10: return 8'h40; 8'h11: return 8'h82;   // or
            8'h12: return 8'h50; 8'h13: return 8'h83;   // and
            8'h14: return 8'h10; 8'h15: return 8'h84;   // store
            8'h16: return 8'h00;                        // no-op
            8'h17: return 8'h7C;                        // undefined code
            8'h18: return 8'h90; 8'h19: return 8'h06;   // jn not taken
            8'h1A: return 8'h80; 8'h1B: return 8'h20;   // jump
            8'h20: return 8'hF0;                        // halt
            8'h80: return 8'h05;
            8'h81: return 8'hFB;
            8'h82: return 8'h0F;
            8'h83: return 8'h3C;
            default: return 8'h00;
        endcase
    endfunction

    // bench datapath: memory, MAR, accumulator, ALU
    logic [7:0] mem [256];
    logic [7:0] mar, ac;

    assign bus_in = mem_rd ? mem[mar] : ac;
    assign flag_n = ac[7];
    assign flag_z = (ac == 8'h00);

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= prog_byte(i);
            mar <= 8'h00;
            ac  <= 8'h00;
        end else begin
            if (mar_load) mar <= mar_src[1] ? bus_in : pc_q;
            if (mem_wr)   mem[mar] <= ac;
            if (acc_load) begin
                case (alu_sel)
                    5'b00001: ac <= bus_in;
                    5'b00010: ac <= ac + bus_in;
                    5'b00100: ac <= ac | bus_in;
                    5'b01000: ac <= ac & bus_in;
                    5'b10000: ac <= ~ac;
                    default:  ac <= 8'hXX;
                endcase
            end
        end
    end

    // scoreboard
    typedef struct { logic [7:0] pc; logic [7:0] ac; logic [3:0] op; } exp_t;
    exp_t exp_q[$];
    logic [7:0] ref_halt_pc;
    logic [7:0] ref_store_val;

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'h1, 4'h2, 4'h3, 4'h4, 4'h5: return "R4";
            4'h6: return "R10";
            4'h8: return "R5";
            4'h9, 4'hA: return "R6";
            default: return "R3";
        endcase
    endfunction

    // driver: instruction-level reference model pushes expected boundaries
    task automatic push_expected();
        logic [7:0] m [256];
        logic [7:0] p, a, opnd;
        logic [3:0] op;
        for (int i = 0; i < 256; i++) m[i] = prog_byte(i);
        p = 0; a = 0;
        for (int k = 0; k < 100; k++) begin
            op = m[p][7:4];
            p = p + 1;
            if (op == 4'hF) break;
            case (op)
                4'h1: begin opnd = m[p]; p = p + 1; m[opnd] = a; ref_store_val = a; end
                4'h2: begin opnd = m[p]; p = p + 1; a = m[opnd]; end
                4'h3: begin opnd = m[p]; p = p + 1; a = a + m[opnd]; end
                4'h4: begin opnd = m[p]; p = p + 1; a = a | m[opnd]; end
                4'h5: begin opnd = m[p]; p = p + 1; a = a & m[opnd]; end
                4'h6: a = ~a;
                4'h8: p = m[p];
                4'h9: p = a[7]      ? m[p] : p + 1;
                4'hA: p = (a == 0)  ? m[p] : p + 1;
                default: ;
            endcase
            exp_q.push_back('{pc: p, ac: a, op: op});
        end
        ref_halt_pc = p;
    endtask

    // monitor
    int       cyc_cnt = 0;
    logic [2:0] prev_step = 0;
    exp_t     e;

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc_cnt = 0;
            prev_step = 0;
        end else if (!halted) begin
            if (step_q == 3'd0 && prev_step == 3'd7) begin
                check(cyc_cnt == 8, "R1", "cycles per instruction", cyc_cnt, 8);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected instruction boundary", 0, 1);
                end else begin
                    e = exp_q.pop_front();
                    check(pc_q == e.pc, req_of(e.op), "pc at boundary", pc_q, e.pc);
                    check(ac == e.ac, req_of(e.op), "acc at boundary", ac, e.ac);
                end
                cyc_cnt = 1;
            end else begin
                cyc_cnt++;
            end
            if (step_q == 3'd0)
                check(mar_load && mar_src == 2'b01 && !mem_rd, "R2", "step0 controls",
                      {mar_load, mar_src}, 3'b101);
            if (step_q == 3'd1)
                check(mem_rd && pc_sel == 2'b01, "R2", "step1 controls", {mem_rd, pc_sel}, 3'b101);
            if (step_q == 3'd2)
                check(mem_rd && ir_load && pc_sel == 2'b00, "R2", "step2 controls",
                      {mem_rd, ir_load, pc_sel}, 4'b1100);
            if (mem_wr)
                check(step_q == 3'd6, "R4", "write step", step_q, 6);
            prev_step = step_q;
        end
    end

    // watchdog
    initial begin
        #(5ns * 150000);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    logic [7:0] pc_hold;
    logic [2:0] st_hold;

    initial begin
        push_expected();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pc_q == 8'h00, "R9", "reset pc", pc_q, 0);
        check(step_q == 3'd0, "R9", "reset step", step_q, 0);
        check(!halted, "R9", "reset halted", halted, 0);
        check(ir_q == 8'h00, "R9", "reset ir", ir_q, 0);
        @(posedge clk); #1 rst_n = 1'b1;

        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
        @(negedge clk);
        check(halted, "R8", "halt reached", halted, 1);
        check(exp_q.size() == 0, "R3", "pending boundaries", exp_q.size(), 0);
        check(pc_q == ref_halt_pc, "R8", "pc after halt", pc_q, ref_halt_pc);
        check(mem[8'h84] == ref_store_val, "R4", "stored byte", mem[8'h84], ref_store_val);
        check(mem[8'h06] == 8'hF0, "R4", "untouched byte", mem[8'h06], 8'hF0);
        pc_hold = pc_q;
        st_hold = step_q;
        repeat (20) @(negedge clk);
        check(pc_q == pc_hold, "R8", "pc frozen", pc_q, pc_hold);
        check(step_q == st_hold, "R8", "step frozen", step_q, st_hold);
        check(halted && pc_sel == 2'b00 && !mem_wr && !acc_load, "R8", "controls idle",
              {halted, pc_sel, mem_wr, acc_load}, 5'b10000);

        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(pc_q == 8'h00 && step_q == 3'd0 && !halted, "R9", "reset after halt",
              {pc_q, step_q, halted}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(ir_q == 8'h20 && pc_q == 8'h01, "R2", "refetch after reset",
              {ir_q, pc_q}, 16'h2001);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule